// File: doc/BRIEF.md
# USB Receive Packet Disassembler

This block sits behind a UTMI-style receive port and turns each received packet, presented as a byte stream, into a classified result. The first byte of a packet is the packet identifier (PID). The block checks the PID's integrity and sorts the packet into one of three classes: token (IN, OUT, SETUP), data (DATA0, DATA1) or handshake (ACK, NAK, STALL). For a token it extracts the device address and endpoint number. For a data packet it streams the payload bytes out as they arrive, but keeps the final two bytes back so that the CRC never appears as payload.

Tokens are checked with CRC5 and data packets with CRC16. Both engines take one byte per clock. When the receive port drops its active qualifier, the block gives exactly one verdict for the packet: good or bad. The class, PID and token fields are updated in the same cycle as the verdict and hold until the next one.

The control is a state machine with six named states:
- `ST_IDLE`: no packet.
- `ST_WAIT_PID`: the packet is active but no byte has arrived yet.
- `ST_TOKEN`, `ST_DATA`, `ST_HSK`: the packet body of each class.
- `ST_DROP`: the PID was corrupt or unsupported.

Transitions:
- `ST_IDLE` → `ST_WAIT_PID` when the packet goes active with no byte.
- `ST_IDLE` or `ST_WAIT_PID` → a body state or `ST_DROP` when the PID byte arrives.
- Any state other than `ST_IDLE` → `ST_IDLE` when the packet ends. This transition issues the verdict.

Top module: `usbrx_disasm`

## Requirements
- R1: After reset `pkt_good`, `pkt_bad` and `pay_valid` are low, `pkt_class` is 0 (none), and `pkt_pid`, `tok_addr` and `tok_ep` are zero.
- R2: A PID byte whose bits [7:4] are not the bitwise inverse of bits [3:0] makes the packet bad, with `pkt_class` 0.
- R3: The token PIDs are, in bits [3:0], OUT=0001, IN=1001 and SETUP=1101. A token with exactly two bytes after the PID and a good CRC5 is good, with `pkt_class`=1. The address `tok_addr` is byte 1 bits [6:0]. The endpoint `tok_ep` is {byte 2 bits [2:0], byte 1 bit 7}.
- R4: CRC5 uses x^5+x^2+1 preset to all ones, run LSB first over both bytes after the PID. A token is accepted only when the residual is 5'b01100; any other residual makes it bad.
- R5: The data PIDs are DATA0=0011 and DATA1=1011, with `pkt_class`=2. CRC16 uses x^16+x^15+x^2+1 preset to all ones, run over every byte after the PID. The packet is good only with residual 16'h800D.
- R6: Payload bytes of a data packet appear on `pay_data`, with a one-cycle `pay_valid`, in arrival order. A byte is released in the cycle after the data byte two positions later arrives. The final two bytes of the packet are never released.
- R7: The handshake PIDs are ACK=0010, NAK=1010 and STALL=1110, with `pkt_class`=3. A handshake is good only with no byte after the PID.
- R8: `rx_error` at any time during a packet makes the packet bad. A byte flagged with `rx_error` is neither forwarded nor counted.
- R9: A wrong length makes the packet bad. For a token this is any count other than two bytes after the PID. For a data packet it is fewer than 2 or more than MAX_PAYLOAD+2 bytes after the PID.
- R10: The verdict is a single-cycle pulse on exactly one of `pkt_good` or `pkt_bad`, in the cycle after `rx_active` falls. `pkt_class`, `pkt_pid`, `tok_addr` and `tok_ep` change only with a verdict.
- R11: A PID with a correct check nibble that is none of the eight listed (for example 0101) makes the packet bad, with `pkt_class` 0.
- R12: A packet during which no byte arrives is bad, with `pkt_class` 0 and `pkt_pid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_active | input | 1 | Packet in progress on the receive port |
| rx_valid | input | 1 | `rx_data` holds a received byte this cycle |
| rx_error | input | 1 | Receive error reported by the PHY |
| rx_data | input | 8 | Received byte |
| pkt_good | output | 1 | One-cycle pulse: packet accepted |
| pkt_bad | output | 1 | One-cycle pulse: packet rejected |
| pkt_class | output | 2 | 0 none, 1 token, 2 data, 3 handshake |
| pkt_pid | output | 4 | PID bits [3:0] of the last packet |
| tok_addr | output | 7 | Token device address |
| tok_ep | output | 4 | Token endpoint number |
| pay_valid | output | 1 | `pay_data` carries a payload byte |
| pay_data | output | 8 | Payload byte |

## Verification
A receive error and a payload release can fall on the same clock edge. This happens when the flagged byte is the one that would push the oldest held-back byte out. The bench raises `rx_error` on the fourth byte of a data packet, which is exactly that release edge. It then counts the payload bytes that emerge: the flagged byte must be skipped and the stream must close up around it. The verdict for that packet must be bad even though the surrounding bytes still flow.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_TOKEN = 2'd1,
        CLS_DATA  = 2'd2,
        CLS_HSK   = 2'd3
    } pkt_class_t;

    localparam logic [3:0] PID_OUT   = 4'b0001;
    localparam logic [3:0] PID_IN    = 4'b1001;
    localparam logic [3:0] PID_SETUP = 4'b1101;
    localparam logic [3:0] PID_DATA0 = 4'b0011;
    localparam logic [3:0] PID_DATA1 = 4'b1011;
    localparam logic [3:0] PID_ACK   = 4'b0010;
    localparam logic [3:0] PID_NAK   = 4'b1010;
    localparam logic [3:0] PID_STALL = 4'b1110;

    localparam logic [4:0]  CRC5_GOOD  = 5'b01100;
    localparam logic [15:0] CRC16_GOOD = 16'h800D;

    function automatic pkt_class_t classify(input logic [3:0] p);
        pkt_class_t c;
        case (p)
            PID_OUT, PID_IN, PID_SETUP: c = CLS_TOKEN;
            PID_DATA0, PID_DATA1:       c = CLS_DATA;
            PID_ACK, PID_NAK, PID_STALL: c = CLS_HSK;
            default:                    c = CLS_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/usbrx_crc.sv
module usbrx_crc #(
    parameter int            W    = 5,
    parameter logic [W-1:0]  POLY = 5'h05,
    parameter logic [W-1:0]  INIT = 5'h1F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed,
    input  logic         en,
    input  logic [7:0]   din,
    output logic [W-1:0] crc
);

    logic [W-1:0] crc_q;
    logic [W-1:0] crc_nxt;

    // Eight serial LSB-first steps unrolled into one clock.
    always_comb begin
        logic fb;
        crc_nxt = crc_q;
        for (int i = 0; i < 8; i++) begin
            fb      = din[i] ^ crc_nxt[W-1];
            crc_nxt = {crc_nxt[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= INIT;
        else if (seed) crc_q <= INIT;
        else if (en)   crc_q <= crc_nxt;
    end

    assign crc = crc_q;

endmodule

// File: rtl/usbrx_holdback.sv
module usbrx_holdback #(
    parameter int DEPTH = 2,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] din,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);

    logic [DW-1:0]    stg [DEPTH];
    logic [DEPTH-1:0] vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg[0] <= '0;
            vld[0] <= 1'b0;
        end else if (clear) begin
            vld[0] <= 1'b0;
        end else if (push) begin
            stg[0] <= din;
            vld[0] <= 1'b1;
        end
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[g] <= '0;
                vld[g] <= 1'b0;
            end else if (clear) begin
                vld[g] <= 1'b0;
            end else if (push) begin
                stg[g] <= stg[g-1];
                vld[g] <= vld[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= push && !clear && vld[DEPTH-1];
            if (push && vld[DEPTH-1]) out_data <= stg[DEPTH-1];
        end
    end

    // R6: a byte only leaves on the edge that accepts a newer one
    assert_release_on_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(push));

endmodule

// File: rtl/usbrx_disasm.sv
module usbrx_disasm
    import usbrx_pkg::*;
#(
    parameter int MAX_PAYLOAD = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_active,
    input  logic       rx_valid,
    input  logic       rx_error,
    input  logic [7:0] rx_data,
    output logic       pkt_good,
    output logic       pkt_bad,
    output logic [1:0] pkt_class,
    output logic [3:0] pkt_pid,
    output logic [6:0] tok_addr,
    output logic [3:0] tok_ep,
    output logic       pay_valid,
    output logic [7:0] pay_data
);

    localparam int CNT_TOP = MAX_PAYLOAD + 3;
    localparam int CNT_W   = $clog2(CNT_TOP + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_PID,
        ST_TOKEN,
        ST_DATA,
        ST_HSK,
        ST_DROP
    } state_t;

    state_t     state_q, state_d;
    logic       bad_q;
    logic [CNT_W-1:0] cnt_q;
    logic [6:0] addr_q;
    logic [3:0] ep_q;
    pkt_class_t cls_q;
    logic [3:0] pid_q;

    logic       byte_ok, start, pid_ev, end_ev, pid_chk_ok;
    pkt_class_t rx_cls;
    logic       in_body, len_crc_ok, good_now;
    logic [4:0]  crc5;
    logic [15:0] crc16;

    assign byte_ok    = rx_active && rx_valid && !rx_error;
    assign start      = (state_q == ST_IDLE) && rx_active;
    assign pid_ev     = byte_ok && (start || state_q == ST_WAIT_PID);
    assign end_ev     = (state_q != ST_IDLE) && !rx_active;
    assign pid_chk_ok = (rx_data[7:4] == ~rx_data[3:0]);
    assign rx_cls     = pid_chk_ok ? classify(rx_data[3:0]) : CLS_NONE;
    assign in_body    = (state_q == ST_TOKEN) || (state_q == ST_DATA) ||
                        (state_q == ST_HSK)   || (state_q == ST_DROP);

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_WAIT_PID: begin
                if (!rx_active) begin
                    state_d = ST_IDLE;
                end else if (byte_ok) begin
                    unique case (rx_cls)
                        CLS_TOKEN: state_d = ST_TOKEN;
                        CLS_DATA:  state_d = ST_DATA;
                        CLS_HSK:   state_d = ST_HSK;
                        CLS_NONE:  state_d = ST_DROP;
                    endcase
                end else begin
                    state_d = ST_WAIT_PID;
                end
            end
            ST_TOKEN, ST_DATA, ST_HSK, ST_DROP: begin
                if (!rx_active) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- packet bookkeeping ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_q  <= 1'b0;
            cnt_q  <= '0;
            addr_q <= '0;
            ep_q   <= '0;
            cls_q  <= CLS_NONE;
            pid_q  <= '0;
        end else begin
            if (start) begin
                bad_q  <= rx_error;
                cnt_q  <= '0;
                addr_q <= '0;
                ep_q   <= '0;
                cls_q  <= CLS_NONE;
                pid_q  <= '0;
            end else if (state_q != ST_IDLE && rx_active && rx_error) begin
                bad_q <= 1'b1;
            end
            if (pid_ev) begin
                cls_q <= rx_cls;
                pid_q <= rx_data[3:0];
            end
            if (byte_ok && in_body && cnt_q != CNT_W'(CNT_TOP)) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (byte_ok && state_q == ST_TOKEN) begin
                if (cnt_q == CNT_W'(0)) begin
                    addr_q  <= rx_data[6:0];
                    ep_q[0] <= rx_data[7];
                end else if (cnt_q == CNT_W'(1)) begin
                    ep_q[3:1] <= rx_data[2:0];
                end
            end
        end
    end

    // ---------------- CRC engines ----------------
    usbrx_crc #(.W(5), .POLY(5'h05), .INIT(5'h1F)) u_crc5 (
        .clk  (clk),
        .rst_n(rst_n),
        .seed (pid_ev),
        .en   (byte_ok && state_q == ST_TOKEN),
        .din  (rx_data),
        .crc  (crc5)
    );

    usbrx_crc #(.W(16), .POLY(16'h8005), .INIT(16'hFFFF)) u_crc16 (
        .clk  (clk),
        .rst_n(rst_n),
        .seed (pid_ev),
        .en   (byte_ok && state_q == ST_DATA),
        .din  (rx_data),
        .crc  (crc16)
    );

    // ---------------- payload holdback ----------------
    usbrx_holdback #(.DEPTH(2), .DW(8)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start || end_ev),
        .push     (byte_ok && state_q == ST_DATA),
        .din      (rx_data),
        .out_valid(pay_valid),
        .out_data (pay_data)
    );

    // ---------------- verdict ----------------
    always_comb begin
        len_crc_ok = 1'b0;
        unique case (state_q)
            ST_TOKEN: len_crc_ok = (cnt_q == CNT_W'(2)) && (crc5 == CRC5_GOOD);
            ST_DATA:  len_crc_ok = (cnt_q >= CNT_W'(2)) &&
                                   (cnt_q <= CNT_W'(MAX_PAYLOAD + 2)) &&
                                   (crc16 == CRC16_GOOD);
            ST_HSK:   len_crc_ok = (cnt_q == CNT_W'(0));
            default:  len_crc_ok = 1'b0;
        endcase
    end

    assign good_now = len_crc_ok && !bad_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_good  <= 1'b0;
            pkt_bad   <= 1'b0;
            pkt_class <= CLS_NONE;
            pkt_pid   <= '0;
            tok_addr  <= '0;
            tok_ep    <= '0;
        end else begin
            pkt_good <= end_ev && good_now;
            pkt_bad  <= end_ev && !good_now;
            if (end_ev) begin
                pkt_class <= cls_q;
                pkt_pid   <= pid_q;
                tok_addr  <= addr_q;
                tok_ep    <= ep_q;
            end
        end
    end

    // ---------------- assertions ----------------
    assert_verdict_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_good && pkt_bad));

    assert_verdict_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_good || pkt_bad) |-> !$past(rx_active));

    assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_good || pkt_bad) |-> $stable(pkt_class) && $stable(tok_addr) && $stable(tok_ep));

    assert_token_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_good && pkt_class == CLS_TOKEN) |-> $past(cnt_q) == CNT_W'(2));

    assert_hsk_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_good && pkt_class == CLS_HSK) |-> $past(cnt_q) == CNT_W'(0));

    assert_payload_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> $past(state_q) == ST_DATA);

endmodule

// File: tb/sim_usbrx_disasm.sv
`timescale 1ns/1ps
module sim_usbrx_disasm;

    localparam int MAXP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_active = 1'b0, rx_valid = 1'b0, rx_error = 1'b0;
    logic [7:0] rx_data = '0;
    logic       pkt_good, pkt_bad, pay_valid;
    logic [1:0] pkt_class;
    logic [3:0] pkt_pid, tok_ep;
    logic [6:0] tok_addr;
    logic [7:0] pay_data;

    always #2 clk = ~clk;

    usbrx_disasm #(.MAX_PAYLOAD(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .rx_valid(rx_valid),
        .rx_error(rx_error), .rx_data(rx_data), .pkt_good(pkt_good), .pkt_bad(pkt_bad),
        .pkt_class(pkt_class), .pkt_pid(pkt_pid), .tok_addr(tok_addr), .tok_ep(tok_ep),
        .pay_valid(pay_valid), .pay_data(pay_data)
    );

    int checks = 0;
    int failures = 0;
    logic [7:0] pb [0:31];
    int pn = 0;
    int err_at = -1;
    logic [7:0] cap [0:31];
    int cap_n = 0;

    always @(negedge clk) begin
        if (pay_valid) begin
            if (cap_n < 32) cap[cap_n] = pay_data;
            cap_n++;
        end
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic logic [4:0] crc5_of(input logic [10:0] d);
        logic [4:0] c = 5'h1F;
        for (int i = 0; i < 11; i++) begin
            logic fb = d[i] ^ c[4];
            c = {c[3:0], 1'b0} ^ (fb ? 5'h05 : 5'h00);
        end
        return c;
    endfunction

    task automatic build_token(input logic [3:0] pid, input logic [6:0] a,
                               input logic [3:0] ep, input bit flip);
        logic [10:0] d = {ep, a};
        logic [4:0]  c = crc5_of(d);
        pb[0] = {~pid, pid};
        pb[1] = d[7:0];
        pb[2] = {5'b0, d[10:8]};
        for (int j = 0; j < 5; j++) pb[2][3+j] = ~c[4-j];
        if (flip) pb[2][7] = ~pb[2][7];
        pn = 3;
    endtask

    task automatic build_data(input logic [3:0] pid, input int n, input bit flip);
        logic [15:0] c = 16'hFFFF;
        pb[0] = {~pid, pid};
        for (int k = 1; k <= n; k++) pb[k] = 8'(8'h3C + k * 37);
        for (int k = 1; k <= n; k++)
            for (int i = 0; i < 8; i++) begin
                logic fb = pb[k][i] ^ c[15];
                c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
            end
        for (int i = 0; i < 8; i++) begin
            pb[n+1][i] = ~c[15-i];
            pb[n+2][i] = ~c[7-i];
        end
        if (flip) pb[n+1][0] = ~pb[n+1][0];
        pn = n + 3;
    endtask

    // Sends pb[0..pn-1]; returns at the negedge where the verdict is visible.
    task automatic send_pkt();
        cap_n = 0;
        @(negedge clk);
        rx_active = 1'b1;
        for (int k = 0; k < pn; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = pb[k]; rx_error = (k == err_at);
            @(negedge clk);
            rx_valid = 1'b0; rx_error = 1'b0;
        end
        @(negedge clk);
        rx_active = 1'b0;
        @(negedge clk);
        err_at = -1;
    endtask

    task automatic expect_verdict(input string req, input bit good, input int cls,
                                  input int pid, input bit tok, input int a, input int ep);
        chk({req, " good"}, int'(pkt_good), int'(good));
        chk({req, " bad"}, int'(pkt_bad), int'(!good));
        chk({req, " class"}, int'(pkt_class), cls);
        chk({req, " pid"}, int'(pkt_pid), pid);
        if (tok) begin
            chk({req, " addr"}, int'(tok_addr), a);
            chk({req, " ep"}, int'(tok_ep), ep);
        end
        @(negedge clk);
        chk("R10 pulse width", int'(pkt_good || pkt_bad), 0);
    endtask

    task automatic t_reset();
        chk("R1 good", int'(pkt_good), 0);
        chk("R1 bad", int'(pkt_bad), 0);
        chk("R1 pay_valid", int'(pay_valid), 0);
        chk("R1 class", int'(pkt_class), 0);
        chk("R1 pid", int'(pkt_pid), 0);
        chk("R1 addr", int'(tok_addr), 0);
        chk("R1 ep", int'(tok_ep), 0);
    endtask

    task automatic t_tokens();
        build_token(4'b0001, 7'h15, 4'hA, 0); send_pkt();
        expect_verdict("R3 OUT", 1, 1, 1, 1, 'h15, 'hA);
        build_token(4'b1001, 7'h7F, 4'h0, 0); send_pkt();
        expect_verdict("R3 IN", 1, 1, 9, 1, 'h7F, 0);
        build_token(4'b1101, 7'h00, 4'hF, 0); send_pkt();
        expect_verdict("R3 SETUP", 1, 1, 13, 1, 0, 'hF);
        build_token(4'b1001, 7'h2B, 4'h5, 1); send_pkt();
        expect_verdict("R4 crc5", 0, 1, 9, 1, 'h2B, 'h5);
        build_token(4'b0001, 7'h11, 4'h3, 0); pb[3] = 8'h55; pn = 4; send_pkt();
        expect_verdict("R9 token long", 0, 1, 1, 0, 0, 0);
    endtask

    task automatic t_data();
        build_data(4'b0011, 4, 0); send_pkt();
        expect_verdict("R5 DATA0", 1, 2, 3, 0, 0, 0);
        chk("R6 payload count", cap_n, 4);
        for (int k = 0; k < 4; k++) chk("R6 payload byte", int'(cap[k]), int'(pb[k+1]));
        build_data(4'b1011, 0, 0); send_pkt();
        expect_verdict("R5 DATA1 empty", 1, 2, 11, 0, 0, 0);
        chk("R6 no payload", cap_n, 0);
        build_data(4'b1011, 3, 1); send_pkt();
        expect_verdict("R5 crc16", 0, 2, 11, 0, 0, 0);
        build_data(4'b0011, MAXP, 0); send_pkt();
        expect_verdict("R9 data max", 1, 2, 3, 0, 0, 0);
        chk("R6 max count", cap_n, MAXP);
        build_data(4'b0011, MAXP + 1, 0); send_pkt();
        expect_verdict("R9 data over", 0, 2, 3, 0, 0, 0);
        pb[0] = 8'hC3; pb[1] = 8'h00; pn = 2; send_pkt();
        expect_verdict("R9 data short", 0, 2, 3, 0, 0, 0);
    endtask

    task automatic t_hsk();
        pb[0] = 8'hD2; pn = 1; send_pkt(); expect_verdict("R7 ACK", 1, 3, 2, 0, 0, 0);
        pb[0] = 8'h5A; pn = 1; send_pkt(); expect_verdict("R7 NAK", 1, 3, 10, 0, 0, 0);
        pb[0] = 8'h1E; pn = 1; send_pkt(); expect_verdict("R7 STALL", 1, 3, 14, 0, 0, 0);
        pb[0] = 8'hD2; pb[1] = 8'h00; pn = 2; send_pkt();
        expect_verdict("R7 ACK extra", 0, 3, 2, 0, 0, 0);
    endtask

    task automatic t_pid_faults();
        pb[0] = 8'hE2; pn = 1; send_pkt();
        expect_verdict("R2 pid check", 0, 0, 2, 0, 0, 0);
        pb[0] = 8'hA5; pb[1] = 8'h00; pb[2] = 8'h00; pn = 3; send_pkt();
        expect_verdict("R11 unsupported", 0, 0, 5, 0, 0, 0);
        pn = 0; send_pkt();
        expect_verdict("R12 empty", 0, 0, 0, 0, 0, 0);
    endtask

    // rx_error on the byte that would release the first payload byte
    task automatic t_rx_error();
        build_data(4'b0011, 4, 0); err_at = 3; send_pkt();
        expect_verdict("R8 rx_error", 0, 2, 3, 0, 0, 0);
        chk("R8 count", cap_n, 3);
        chk("R8 byte0", int'(cap[0]), int'(pb[1]));
        chk("R8 byte2", int'(cap[2]), int'(pb[4]));
        build_token(4'b0001, 7'h01, 4'h1, 0); err_at = 1; send_pkt();
        expect_verdict("R8 token err", 0, 1, 1, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tokens();
        t_data();
        t_hsk();
        t_pid_faults();
        t_rx_error();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule